// File: doc/BRIEF.md
# NAND Attribute-Space Access Timing Sequencer

This block produces the strobe timing for a single read or write to the attribute memory space of a NAND flash socket. A requester presents a direction, an address, write data and a 32-bit timing word, and pulses a request. The block then runs three phases. First it drives the address for a setup time. Next it asserts the correct active-low enable for a programmed width, and stretches that width while the external wait pin is low. Last it holds the address for a hold time. That hold is two cycles longer on a read than on a write.

On a write, the data bus stays high-impedance for a programmed number of cycles from the start of the access. After that the write data is driven until the access ends. On a read the bus is never driven. The block captures the read data as the output enable deasserts and returns it with a one-cycle done pulse. A busy flag covers the whole access, and requests that arrive while it is set are dropped.

Top module: `nand_attr_seq`

## Requirements
- R1: After reset and whenever idle, `we_n` and `oe_n` are high, and `busy`, `done` and `data_oe` are low.
- R2: The timing word is sampled only on the cycle a request is accepted. Its fields are: setup count in bits 7:0, strobe-wait count in bits 15:8, hold count in bits 23:16 and Hi-Z count in bits 31:24. Changing the word during an access has no effect.
- R3: From acceptance, `mem_addr` carries the request address and stays stable for the whole access. Exactly setup+1 busy cycles pass before the enable strobe asserts.
- R4: A write asserts only `we_n` and a read asserts only `oe_n`. The strobe lasts at least wait+1 cycles.
- R5: If the synchronized `wait_n` is low when the programmed strobe time ends, the strobe stays asserted until it is sampled high. `wait_n` passes through two flops, so the strobe lasts max(wait+1, K+2) cycles when `wait_n` rises in the K-th strobe cycle.
- R6: On a write, busy lasts exactly hold cycles after the strobe deasserts. The address and `data_out` stay driven during that time.
- R7: On a read, busy lasts exactly hold+2 cycles after the strobe deasserts.
- R8: On a write, `data_oe` is low for the first Hi-Z-count busy cycles. It is then high, with `data_out` equal to the write data, until the access ends.
- R9: On a read, `data_oe` is never high, whatever the Hi-Z count is.
- R10: `rd_data` takes the value on `data_in` at the edge where `oe_n` deasserts. `done` pulses high for one cycle in the first cycle after the hold phase, and `busy` falls in that same cycle.
- R11: A request that arrives while `busy` is high is ignored. The address and timing do not change, and no second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request pulse, accepted when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| timing_word | input | 32 | Packed setup/wait/hold/Hi-Z counts |
| wait_n | input | 1 | Asynchronous active-low wait from the device |
| data_in | input | DW | Data bus input from the device |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DW | Captured read data |
| mem_addr | output | AW | Address to the device |
| we_n | output | 1 | Active-low write enable |
| oe_n | output | 1 | Active-low output enable |
| data_oe | output | 1 | Data bus output enable |
| data_out | output | DW | Data bus output value |

## Verification
The hardest case to reach is stretching the strobe with the wait pin. The synchronizer delay means the release point has to be placed against the strobe cycle count and not against the raw pin. The bench holds `wait_n` low from the request onward. It releases the pin at a chosen strobe cycle beyond the programmed width and expects two extra cycles of strobe. The stale-timing case is reached by inverting the timing word on the cycle right after acceptance. The busy-drop case is reached by pulsing a conflicting request during setup.

// File: rtl/nand_attr_seq.sv
module nand_attr_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [31:0]   timing_word,
  input  logic          wait_n,
  input  logic [DW-1:0] data_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          we_n,
  output logic          oe_n,
  output logic          data_oe,
  output logic [DW-1:0] data_out
);
  localparam int FW = 8;
  localparam int CW = FW + 1;
  localparam logic [CW-1:0] RD_EXTRA = CW'(2);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [FW-1:0] hiz_cnt, wait_fld, hold_fld;
  logic          is_wr;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rd_q;
  logic          done_q;
  logic [1:0]    wsync;
  logic [CW-1:0] hold_total;

  assign hold_total = is_wr ? {1'b0, hold_fld} : {1'b0, hold_fld} + RD_EXTRA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      hiz_cnt  <= '0;
      wait_fld <= '0;
      hold_fld <= '0;
      is_wr    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_q     <= '0;
      done_q   <= 1'b0;
      wsync    <= 2'b11;
    end else begin
      done_q <= 1'b0;
      wsync  <= {wsync[0], wait_n};
      if (st != S_IDLE && hiz_cnt != '0) hiz_cnt <= hiz_cnt - 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          is_wr    <= req_write;
          addr_q   <= req_addr;
          wdata_q  <= req_wdata;
          cnt      <= {1'b0, timing_word[7:0]};
          wait_fld <= timing_word[15:8];
          hold_fld <= timing_word[23:16];
          hiz_cnt  <= req_write ? timing_word[31:24] : '0;
          st       <= S_SETUP;
        end
        S_SETUP: if (cnt == '0) begin
          cnt <= {1'b0, wait_fld};
          st  <= S_STROBE;
        end else cnt <= cnt - 1'b1;
        S_STROBE: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (wsync[1]) begin
          if (!is_wr) rd_q <= data_in;
          if (hold_total == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt <= hold_total - 1'b1;
            st  <= S_HOLD;
          end
        end
        S_HOLD: if (cnt == '0) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign rd_data  = rd_q;
  assign mem_addr = addr_q;
  assign we_n     = !(st == S_STROBE && is_wr);
  assign oe_n     = !(st == S_STROBE && !is_wr);
  assign data_oe  = is_wr && busy && (hiz_cnt == '0);
  assign data_out = wdata_q;
endmodule

module nand_attr_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          we_n,
  input logic          oe_n,
  input logic          data_oe,
  input logic [AW-1:0] mem_addr
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && oe_n && !data_oe));
  p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  p_read_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !data_oe);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind nand_attr_seq nand_attr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .we_n(we_n),
  .oe_n(oe_n), .data_oe(data_oe), .mem_addr(mem_addr)
);

// File: tb/sim_nand_attr_seq.sv
module sim_nand_attr_seq;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, wait_n = 1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, data_in = '0;
  logic [31:0] timing_word = '0;
  logic busy, done, we_n, oe_n, data_oe;
  logic [DW-1:0] rd_data, data_out;
  logic [AW-1:0] mem_addr;

  int total = 0, bad = 0, cyc = 0;
  int n_setup, n_strobe, n_hold, n_hiz;
  bit e_addr, e_wrong, e_drive, e_data, e_oedrop;

  nand_attr_seq #(.AW(AW), .DW(DW)) u0 (.*);

  always #5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [31:0] tw, input logic [DW-1:0] rdv,
                        input int rel_at, input int stray_at);
    bit struck, oe_seen;
    int busy_cycles;
    n_setup = 0; n_strobe = 0; n_hold = 0; n_hiz = 0;
    e_addr = 0; e_wrong = 0; e_drive = 0; e_data = 0; e_oedrop = 0;
    struck = 0; oe_seen = 0; busy_cycles = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; timing_word = tw;
    if (rel_at >= 0) wait_n = 0;
    @(negedge clk);
    req_valid = 0; timing_word = ~tw; req_addr = ~a; req_wdata = ~wd;
    for (int i = 0; i < 3000; i++) begin
      if (done) break;
      busy_cycles++;
      if (busy_cycles == stray_at) req_valid = 1;
      else req_valid = 0;
      if (mem_addr !== a) e_addr = 1;
      if (wr ? !oe_n : !we_n) e_wrong = 1;
      if (!wr && data_oe) e_drive = 1;
      if (data_oe && data_out !== wd) e_data = 1;
      if (wr && oe_seen && !data_oe) e_oedrop = 1;
      if (data_oe) oe_seen = 1;
      else if (wr) n_hiz++;
      if ((wr ? we_n : oe_n) == 1'b0) begin
        struck = 1; n_strobe++;
        if (n_strobe == rel_at) wait_n = 1;
      end else if (!struck) n_setup++;
      else n_hold++;
      data_in = (!oe_n) ? rdv : ~rdv;
      @(negedge clk);
    end
    req_valid = 0;
    wait_n = 1;
  endtask

  task automatic t_reset;
    chk(we_n === 1'b1 && oe_n === 1'b1, "R1 strobes idle high", {we_n, oe_n}, 3);
    chk(busy === 1'b0, "R1 busy low", busy, 0);
    chk(done === 1'b0, "R1 done low", done, 0);
    chk(data_oe === 1'b0, "R1 data_oe low", data_oe, 0);
  endtask

  task automatic t_write_basic;
    access(1, 16'h1234, 8'hA5, {8'd1, 8'd4, 8'd2, 8'd3}, 8'h00, -1, -1);
    chk(n_setup == 4, "R3 write setup", n_setup, 4);
    chk(!e_addr, "R3 address stable", e_addr, 0);
    chk(n_strobe == 3, "R4 write strobe width", n_strobe, 3);
    chk(!e_wrong, "R4 only we_n on write", e_wrong, 0);
    chk(n_hold == 4, "R6 write hold", n_hold, 4);
    chk(n_hiz == 1, "R8 write hi-z", n_hiz, 1);
    chk(!e_data && !e_oedrop, "R8 data driven", {e_data, e_oedrop}, 0);
    chk(n_setup + n_strobe + n_hold == 11, "R2 word sampled at accept", n_setup + n_strobe + n_hold, 11);
    chk(busy === 1'b0, "R10 busy falls with done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", done, 0);
  endtask

  task automatic t_read_basic;
    access(0, 16'hBEEF, 8'h00, {8'd5, 8'd2, 8'd3, 8'd1}, 8'h3C, -1, -1);
    chk(n_setup == 2, "R3 read setup", n_setup, 2);
    chk(n_strobe == 4, "R4 read strobe width", n_strobe, 4);
    chk(!e_wrong, "R4 only oe_n on read", e_wrong, 0);
    chk(n_hold == 4, "R7 read hold", n_hold, 4);
    chk(!e_drive, "R9 no drive on read", e_drive, 0);
    chk(rd_data === 8'h3C, "R10 read capture", rd_data, 8'h3C);
  endtask

  task automatic t_zero_counts;
    access(1, 16'h0001, 8'h5A, 32'h0, 8'h00, -1, -1);
    chk(n_setup == 1 && n_strobe == 1, "R4 zero write phases", n_setup * 10 + n_strobe, 11);
    chk(n_hold == 0, "R6 zero write hold", n_hold, 0);
    chk(n_hiz == 0 && !e_data, "R8 zero hi-z", n_hiz, 0);
    access(0, 16'h0002, 8'h00, 32'h0, 8'hC3, -1, -1);
    chk(n_hold == 2, "R7 zero read hold", n_hold, 2);
    chk(rd_data === 8'hC3, "R10 zero read capture", rd_data, 8'hC3);
  endtask

  task automatic t_wait_stretch;
    access(1, 16'h0F0F, 8'h77, {8'd0, 8'd1, 8'd2, 8'd0}, 8'h00, 6, -1);
    chk(n_strobe == 8, "R5 wait extension", n_strobe, 8);
    chk(n_hold == 1, "R6 hold after extension", n_hold, 1);
    access(0, 16'h0F10, 8'h00, {8'd0, 8'd0, 8'd5, 8'd0}, 8'h99, 2, -1);
    chk(n_strobe == 6, "R5 wait under programmed width", n_strobe, 6);
  endtask

  task automatic t_busy_ignore;
    access(1, 16'h4444, 8'h11, {8'd0, 8'd2, 8'd1, 8'd3}, 8'h00, -1, 2);
    chk(!e_addr, "R11 stray request keeps address", e_addr, 0);
    chk(n_setup == 4 && n_strobe == 2, "R11 timing unchanged", n_setup * 10 + n_strobe, 42);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(busy === 1'b0, "R11 no second access", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_basic();
    t_read_basic();
    t_zero_counts();
    t_wait_stretch();
    t_busy_ignore();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule